// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable model of a synchronous static memory where reads and writes can follow each other on every clock. No idle cycle is needed when the bus changes direction. Each word is 36 bits wide and is split into four 9-bit lanes, each holding 8 data bits and 1 parity bit. An access is started by a load edge. At that edge the address, the access type and the lane selects are captured. Write data arrives one qualified clock later, and a new access may start on that same edge.

Read data is flow-through. It comes straight from the storage at the registered address during the cycle after the load edge, with no second output register. A small burst generator can step through up to four words from one loaded address, in linear or interleaved order. The data bus is split into `din`, `dout` and a drive enable `dout_en`, which takes the place of a bidirectional pin. The enclosing logic uses `dout_en` to control a pad or to check for contention. The depth is a parameter and is kept small for simulation.

Top module: `zft_sram`

## Requirements
- R1: The block counts as selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A load edge with any one of them inactive is a deselect: no storage location changes and the output stays off.
- R2: With `cke_n`=1 a rising clock is ignored. The access state, the burst position and a pending write all hold. The pending write then takes its data at the next edge that has `cke_n`=0.
- R3: A qualified edge with `ld_n`=0 while selected starts an access at `addr`. `wr_n`=0 makes it a write and `wr_n`=1 makes it a read. A write stores `din` at the next qualified edge, and that edge may itself start any new access.
- R4: Lane i is `din`/`dout` bits [9i+8:9i]. It is written only if `lane_wr_n[i]`=0 at the edge that presented the address. Other lanes keep their contents, and `lane_wr_n`=4'b1111 writes nothing.
- R5: In the cycle after a read's address edge, `dout` holds the word stored at that address. This includes a write that completed on that same edge.
- R6: `dout_en` is 1 only in a read data cycle with `oe_n`=0, and `oe_n` acts without a clock. Whenever `dout_en` is 0, `dout` is all zeros.
- R7: During a write data cycle, and while deselected, `dout_en` is 0 whatever the value of `oe_n`.
- R8: While `rst_n`=0 and after it is released, the block is deselected with `dout_en`=0 until a load edge.
- R9: A qualified edge with `ld_n`=1 during an active access advances the burst. The access type is kept, and the chip enables and `wr_n` are ignored. `lane_wr_n` is sampled again for the next word.
- R10: The burst changes only address bits [1:0]. On advance step k (modulo 4, so it wraps), those bits equal start+k when `burst_ilv`=0 (linear) and start XOR k when `burst_ilv`=1 (interleaved).
- R11: An advance edge while deselected leaves the block deselected. A fresh load (`ld_n`=0) is needed before the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cke_n | input | 1 | Clock qualifier, active low |
| sel1_n | input | 1 | Chip enable, active low |
| sel2 | input | 1 | Chip enable, active high |
| sel3_n | input | 1 | Chip enable, active low |
| ld_n | input | 1 | 0 = load new address, 1 = advance burst |
| wr_n | input | 1 | Access type at load: 0 write, 1 read |
| lane_wr_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| addr | input | 6 | Word address |
| din | input | 36 | Write data |
| dout | output | 36 | Read data, zero when not driven |
| dout_en | output | 1 | Output drive enable |

## Verification
The bench first fills every word with single writes placed back to back. This shows that a write's data is taken one edge after its address while the next address is loaded on that same edge.

Directed sequences then probe the corners:
- a write directly followed by a read of the same word, which separates flow-through from a stale read;
- partial and empty lane masks, which separate the lanes;
- clock-enable stalls inside a pending write, which separate hold from a dropped write;
- each chip enable inactive in turn;
- bursts in both orders that wrap past the fourth word, with the enables and `wr_n` toggled while advancing.

Constrained random traffic in both burst modes then mixes all of these. A reference model in the bench predicts `dout` and `dout_en` in every cycle, so any ordering slip or lost write shows up as a mismatch.

// File: rtl/zft_pkg.sv
// Shared types and helpers for the zero-turnaround SRAM.
// Assumes a four-word burst window on address bits [1:0].
package zft_pkg;

    // Kind of access occupying the current data cycle
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    // Width of the burst step counter (four-word window)
    localparam int unsigned STEP_W = 2;

    // Low address bits for burst step 'step' from start 'start'
    function automatic logic [STEP_W-1:0] burst_low(
        input logic [STEP_W-1:0] start,
        input logic [STEP_W-1:0] step,
        input logic              ilv
    );
        return ilv ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/zft_burst_seq.sv
// Burst address former: combines the loaded base address with the
// burst step. Only the low STEP_W bits move; upper bits pass through.
// Assumes ADDR_W >= STEP_W.
module zft_burst_seq
    import zft_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [STEP_W-1:0] step,
    input  logic              ilv,
    output logic [ADDR_W-1:0] cur_addr
);

    // Low bits follow the selected burst order
    logic [STEP_W-1:0] low_bits;
    always_comb low_bits = burst_low(base[STEP_W-1:0], step, ilv);

    // Upper bits are fixed for the whole burst when present
    generate
        if (ADDR_W > STEP_W) begin : g_wide
            assign cur_addr = {base[ADDR_W-1:STEP_W], low_bits};
        end else begin : g_narrow
            assign cur_addr = low_bits;
        end
    endgenerate

endmodule

// File: rtl/zft_ctrl.sv
// Access control: decodes the select lines, holds the access type,
// base address, burst step and lane mask of the current data cycle,
// and issues the write commit and the registered output-drive flag.
// Assumes the clock qualifier gates every state change.
module zft_ctrl
    import zft_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              ld_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    output acc_e              acc_st,
    output logic [ADDR_W-1:0] base,
    output logic [STEP_W-1:0] step,
    output logic [LANES-1:0]  lane_en,
    output logic              commit,
    output logic              drive
);

    acc_e              st_q, st_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic [LANES-1:0]  lanes_q, lanes_d;
    logic              drive_q;
    logic              sel_ok;
    logic              edge_ok;

    // Select decode and clock qualification
    always_comb begin
        sel_ok  = ~sel1_n & sel2 & ~sel3_n;
        edge_ok = ~cke_n;
    end

    // Next-state selection for load, advance, deselect and hold
    always_comb begin
        st_d    = st_q;
        base_d  = base_q;
        step_d  = step_q;
        lanes_d = lanes_q;
        if (edge_ok) begin
            if (!ld_n) begin
                if (sel_ok) begin
                    st_d    = wr_n ? ACC_READ : ACC_WRITE;
                    base_d  = addr;
                    step_d  = '0;
                    lanes_d = ~lane_wr_n;
                end else begin
                    st_d    = ACC_IDLE;
                    lanes_d = '0;
                end
            end else if (st_q != ACC_IDLE) begin
                step_d  = step_q + 1'b1;
                lanes_d = ~lane_wr_n;
            end
        end
    end

    // State registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ACC_IDLE;
            base_q  <= '0;
            step_q  <= '0;
            lanes_q <= '0;
            drive_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            base_q  <= base_d;
            step_q  <= step_d;
            lanes_q <= lanes_d;
            drive_q <= (st_d == ACC_READ);
        end
    end

    // Outputs to the storage and the output stage
    always_comb begin
        acc_st  = st_q;
        base    = base_q;
        step    = step_q;
        lane_en = lanes_q;
        commit  = rst_n & edge_ok & (st_q == ACC_WRITE);
        drive   = drive_q;
    end

endmodule

// File: rtl/zft_array.sv
// Word storage built from one bank per lane, so that each lane has
// its own write gate. The read is asynchronous (flow-through); the
// write happens on the clock edge. Contents are not reset.
module zft_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] bank [DEPTH];

            // Lane write gated by its own select
            always_ff @(posedge clk) begin
                if (we && lane_en[g]) begin
                    bank[addr] <= wdata[g*LANE_W +: LANE_W];
                end
            end

            // Flow-through read of this lane
            assign rdata[g*LANE_W +: LANE_W] = bank[addr];
        end
    endgenerate

endmodule

// File: rtl/zft_sram.sv
// Top of the zero-turnaround flow-through synchronous SRAM.
// Write data follows its address by one qualified edge; read data
// flows straight from storage in the cycle after the address edge.
// Assumes burst_ilv is static while an access is active.
module zft_sram
    import zft_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    ld_n,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    oe_n,
    input  logic                    burst_ilv,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);

    localparam int unsigned WORD_W = LANES * LANE_W;

    acc_e              acc_st;
    logic [ADDR_W-1:0] base;
    logic [STEP_W-1:0] step;
    logic [LANES-1:0]  lane_en;
    logic              commit;
    logic              drive;
    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] rdata;
    logic              acc_active;
    logic              acc_write;

    zft_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke_n     (cke_n),
        .sel1_n    (sel1_n),
        .sel2      (sel2),
        .sel3_n    (sel3_n),
        .ld_n      (ld_n),
        .wr_n      (wr_n),
        .lane_wr_n (lane_wr_n),
        .addr      (addr),
        .acc_st    (acc_st),
        .base      (base),
        .step      (step),
        .lane_en   (lane_en),
        .commit    (commit),
        .drive     (drive)
    );

    zft_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .base     (base),
        .step     (step),
        .ilv      (burst_ilv),
        .cur_addr (cur_addr)
    );

    zft_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .we      (commit),
        .lane_en (lane_en),
        .addr    (cur_addr),
        .wdata   (din),
        .rdata   (rdata)
    );

    // Access summary for observation by the checker
    always_comb begin
        acc_active = (acc_st != ACC_IDLE);
        acc_write  = (acc_st == ACC_WRITE);
    end

    // Output stage: registered drive flag gated by the async enable
    always_comb begin
        dout_en = drive & ~oe_n;
        dout    = dout_en ? rdata : '0;
    end

endmodule

// File: rtl/zft_sram_chk.sv
// Property checker for zft_sram, attached through bind.
// Observes ports plus the access summary and the burst address.
module zft_sram_chk #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned WORD_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_n,
    input logic              sel1_n,
    input logic              sel2,
    input logic              sel3_n,
    input logic              ld_n,
    input logic              wr_n,
    input logic              oe_n,
    input logic              burst_ilv,
    input logic [WORD_W-1:0] dout,
    input logic              dout_en,
    input logic              acc_active,
    input logic              acc_write,
    input logic [ADDR_W-1:0] cur_addr
);

    logic sel;
    always_comb sel = !sel1_n && sel2 && !sel3_n;

    // R7
    wr_data_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !ld_n && sel && !wr_n) |=> !dout_en);

    // R6
    en_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !oe_n);

    // R6
    zero_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(cur_addr) && $stable(acc_active) && $stable(acc_write)));

    // R1
    desel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !ld_n && !sel) |=> (!acc_active && !dout_en));

    // R3
    read_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !ld_n && sel && wr_n) |=> (acc_active && !acc_write));

    // R9
    burst_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && ld_n && acc_active) |=> (acc_active && (acc_write == $past(acc_write))));

    // R10
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && ld_n && acc_active && !burst_ilv) |=>
            (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

    // R10
    burst_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && ld_n && acc_active) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

    // R11
    idle_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && ld_n && !acc_active) |=> !acc_active);

endmodule

bind zft_sram zft_sram_chk #(.ADDR_W(ADDR_W), .WORD_W(LANES*LANE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke_n      (cke_n),
    .sel1_n     (sel1_n),
    .sel2       (sel2),
    .sel3_n     (sel3_n),
    .ld_n       (ld_n),
    .wr_n       (wr_n),
    .oe_n       (oe_n),
    .burst_ilv  (burst_ilv),
    .dout       (dout),
    .dout_en    (dout_en),
    .acc_active (acc_active),
    .acc_write  (acc_write),
    .cur_addr   (cur_addr)
);

// File: tb/tb_zft_sram.sv
`timescale 1ns/100ps
module tb_zft_sram;

    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int WW = NL * LW;
    localparam int DEPTH = 1 << AW;
    localparam logic [2:0] SEL_ON = 3'b010;   // {sel1_n, sel2, sel3_n}

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b0;
    logic          sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
    logic          ld_n = 1'b0, wr_n = 1'b1;
    logic [NL-1:0] lane_wr_n = '1;
    logic          oe_n = 1'b0;
    logic          burst_ilv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [WW-1:0] din = '0;
    logic [WW-1:0] dout;
    logic          dout_en;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string tag = "R8";

    // Reference model state
    logic [WW-1:0] mmem [DEPTH];
    int            m_st = 0;       // 0 idle, 1 read, 2 write
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_k = '0;
    logic [NL-1:0] m_bm = '0;

    zft_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel1_n(sel1_n), .sel2(sel2),
        .sel3_n(sel3_n), .ld_n(ld_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
        .oe_n(oe_n), .burst_ilv(burst_ilv), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    always #2.5 clk = ~clk;

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] lo;
        lo = burst_ilv ? (m_base[1:0] ^ m_k) : (m_base[1:0] + m_k);
        return {m_base[AW-1:2], lo};
    endfunction

    function automatic logic [WW-1:0] rnd_word();
        return {$urandom, $urandom};
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Compare outputs with the model's prediction for this cycle
    task automatic check_out();
        logic          e_en;
        logic [WW-1:0] e_d;
        e_en = (m_st == 1) && !oe_n;
        e_d  = e_en ? mmem[m_addr()] : '0;
        checks++;
        if (dout_en !== e_en) begin
            failures++;
            $display("FAIL %s dout_en actual=%0b expected=%0b t=%0t", tag, dout_en, e_en, $time);
        end
        checks++;
        if (dout !== e_d) begin
            failures++;
            $display("FAIL %s dout actual=%h expected=%h t=%0t", tag, dout, e_d, $time);
        end
    endtask

    // Model update at a rising edge from the inputs then applied
    task automatic model_edge();
        logic sel;
        if (!rst_n) begin
            m_st = 0; m_base = '0; m_k = '0; m_bm = '0;
            return;
        end
        if (cke_n) return;
        if (m_st == 2) begin
            for (int i = 0; i < NL; i++)
                if (m_bm[i]) mmem[m_addr()][i*LW +: LW] = din[i*LW +: LW];
        end
        sel = !sel1_n && sel2 && !sel3_n;
        if (!ld_n) begin
            if (sel) begin
                m_st = wr_n ? 1 : 2; m_base = addr; m_k = '0; m_bm = ~lane_wr_n;
            end else begin
                m_st = 0; m_bm = '0;
            end
        end else if (m_st != 0) begin
            m_k = m_k + 2'd1; m_bm = ~lane_wr_n;
        end
    endtask

    // One clock: check, drive new inputs, advance model at the edge
    task automatic step(input logic ck, input logic ld, input logic [2:0] ce,
                        input logic w, input logic [NL-1:0] bs, input logic o,
                        input logic [AW-1:0] a, input logic [WW-1:0] d);
        @(negedge clk);
        check_out();
        cke_n = ck; ld_n = ld; {sel1_n, sel2, sel3_n} = ce; wr_n = w;
        lane_wr_n = bs; oe_n = o; addr = a; din = d;
        @(posedge clk);
        #1;
        model_edge();
    endtask

    task automatic wr_ld(input logic [AW-1:0] a, input logic [NL-1:0] bs, input logic [WW-1:0] d);
        step(1'b0, 1'b0, SEL_ON, 1'b0, bs, 1'b0, a, d);
    endtask

    task automatic rd_ld(input logic [AW-1:0] a, input logic o, input logic [WW-1:0] d);
        step(1'b0, 1'b0, SEL_ON, 1'b1, 4'hF, o, a, d);
    endtask

    task automatic desel(input logic [WW-1:0] d);
        step(1'b0, 1'b0, 3'b110, 1'b1, 4'hF, 1'b0, '0, d);
    endtask

    task automatic adv(input logic [2:0] ce, input logic w, input logic [NL-1:0] bs, input logic [WW-1:0] d);
        step(1'b0, 1'b1, ce, w, bs, 1'b0, '0, d);
    endtask

    // Watchdog: counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) mmem[i] = '0;

        // R8: reset state with output enable active
        tag = "R8";
        repeat (3) step(1'b0, 1'b0, SEL_ON, 1'b1, 4'hF, 1'b0, 6'd3, '0);
        rst_n = 1'b1;
        desel('0);
        desel('0);

        // R3: fill every word with back-to-back single writes
        tag = "R3";
        wr_ld(6'd0, 4'h0, '0);
        for (int i = 1; i < DEPTH; i++) begin
            logic [WW-1:0] w0;
            w0 = rnd_word();
            wr_ld(AW'(i), 4'h0, w0);
        end
        desel(rnd_word());

        // R5: write then read the same word immediately
        tag = "R5";
        wr_ld(6'd9, 4'h0, '0);
        rd_ld(6'd9, 1'b0, 36'h9_1234_5678);
        rd_ld(6'd10, 1'b0, '0);
        wr_ld(6'd10, 4'h0, '0);
        rd_ld(6'd10, 1'b0, 36'hA_AAAA_5555);
        rd_ld(6'd9, 1'b0, '0);

        // R4: partial lane mask, then an empty mask
        tag = "R4";
        wr_ld(6'd5, 4'b1010, '0);
        rd_ld(6'd5, 1'b0, 36'hF_FFFF_FFFF);
        wr_ld(6'd6, 4'b1111, '0);
        rd_ld(6'd6, 1'b0, 36'h0_0000_0000);
        wr_ld(6'd7, 4'b0111, '0);
        rd_ld(6'd7, 1'b0, 36'h1_2345_6789);

        // R2: stall inside a pending write and inside a read
        tag = "R2";
        wr_ld(6'd12, 4'h0, '0);
        step(1'b1, 1'b0, 3'b110, 1'b1, 4'hF, 1'b0, 6'd1, 36'hD_EAD0_0000);
        step(1'b1, 1'b1, SEL_ON, 1'b0, 4'h0, 1'b0, 6'd2, 36'hB_AD00_0000);
        rd_ld(6'd12, 1'b0, 36'h7_7777_0012);
        step(1'b1, 1'b0, SEL_ON, 1'b0, 4'h0, 1'b0, 6'd13, 36'hC_0000_0001);
        step(1'b1, 1'b0, 3'b000, 1'b0, 4'h0, 1'b0, 6'd13, 36'hC_0000_0002);
        desel('0);

        // R1: each chip enable inactive in turn blocks reads and writes
        tag = "R1";
        step(1'b0, 1'b0, 3'b110, 1'b0, 4'h0, 1'b0, 6'd20, '0);
        step(1'b0, 1'b0, 3'b000, 1'b0, 4'h0, 1'b0, 6'd20, 36'hE_0000_0001);
        step(1'b0, 1'b0, 3'b011, 1'b0, 4'h0, 1'b0, 6'd20, 36'hE_0000_0002);
        step(1'b0, 1'b0, 3'b011, 1'b1, 4'hF, 1'b0, 6'd20, 36'hE_0000_0003);
        rd_ld(6'd20, 1'b0, 36'hE_0000_0004);
        desel('0);

        // R6 and R7: output enable, write data cycle forced off
        tag = "R6";
        rd_ld(6'd21, 1'b1, '0);
        rd_ld(6'd22, 1'b0, '0);
        tag = "R7";
        wr_ld(6'd22, 4'h0, '0);
        rd_ld(6'd23, 1'b0, 36'h3_3333_3333);
        desel('0);
        desel('0);

        // R9 and R10: linear burst read wrapping, enables and wr_n ignored
        tag = "R10";
        burst_ilv = 1'b0;
        rd_ld(6'd30, 1'b0, '0);
        tag = "R9";
        adv(3'b110, 1'b0, 4'h0, 36'h1);
        adv(3'b000, 1'b0, 4'h0, 36'h2);
        adv(SEL_ON, 1'b1, 4'h0, 36'h3);
        tag = "R10";
        adv(SEL_ON, 1'b1, 4'hF, 36'h4);
        desel('0);

        // R10: interleaved burst write with changing lane masks, then read back
        burst_ilv = 1'b1;
        desel('0);
        wr_ld(6'd41, 4'h0, '0);
        adv(SEL_ON, 1'b1, 4'b1100, 36'h1_1111_1111);
        adv(3'b110, 1'b1, 4'h0, 36'h2_2222_2222);
        adv(SEL_ON, 1'b0, 4'b0101, 36'h3_3333_3333);
        adv(SEL_ON, 1'b0, 4'hF, 36'h4_4444_4444);
        desel('0);
        rd_ld(6'd43, 1'b0, '0);
        adv(SEL_ON, 1'b0, 4'h0, '0);
        adv(SEL_ON, 1'b0, 4'h0, '0);
        adv(SEL_ON, 1'b0, 4'h0, '0);
        adv(SEL_ON, 1'b0, 4'h0, '0);

        // R11: advance while deselected stays deselected
        tag = "R11";
        desel('0);
        adv(SEL_ON, 1'b1, 4'h0, '0);
        adv(SEL_ON, 1'b0, 4'h0, 36'h5_5555_5555);
        rd_ld(6'd50, 1'b0, '0);
        desel('0);

        // Random traffic in both burst orders (R3, R4, R5, R6, R9, R10)
        for (int mode = 0; mode < 2; mode++) begin
            desel('0);
            burst_ilv = mode[0];
            tag = mode[0] ? "R10_ilv_rand R3 R4 R5 R6 R9" : "R10_lin_rand R3 R4 R5 R6 R9";
            for (int n = 0; n < 3000; n++) begin
                logic [2:0] ce;
                ce = SEL_ON;
                if ($urandom_range(0, 99) < 5) ce[2] = 1'b1;
                if ($urandom_range(0, 99) < 5) ce[1] = 1'b0;
                if ($urandom_range(0, 99) < 5) ce[0] = 1'b1;
                step($urandom_range(0, 99) < 10,
                     $urandom_range(0, 99) < 35,
                     ce,
                     $urandom_range(0, 1) == 1,
                     NL'($urandom),
                     $urandom_range(0, 99) < 15,
                     AW'($urandom),
                     rnd_word());
            end
        end
        desel('0);
        @(negedge clk);
        check_out();
        summary();
    end

endmodule